// File: doc/BRIEF.md
# Burst SRAM address sequencer

This block sits at the front of a synchronous burst static memory and turns the strobe, enable and advance inputs into a word address plus a few cycle flags for the datapath. On each rising clock edge it looks at two active-low address strobes, one for a processor and one for a cache controller. It also samples an active-low advance input, three chip enables with mixed polarity and a burst-order select. A strobe that finds the chip enabled latches the upper address bits and starts a short burst counter on the lowest address bits.

On the cycles that follow, with neither strobe low, the advance input either steps the counter or holds it, which suspends the burst. The counter steps in linear order or in XOR-interleaved order and returns to its starting value after a full pass. A strobe that finds the chip disabled produces no access and puts the block into its deselected state. All outputs are registered, so every output describes the cycle captured at the latest clock edge. The processor strobe is masked by the first enable, and a cycle started by it is always reported as a read.

Top module: `bsram_addr_seq`

## Requirements
- R1: A strobe cycle (processor strobe accepted, or controller strobe low) selects the chip only when `en1_n`=0, `en2`=1 and `en3_n`=0. Otherwise, after that edge, `desel`=1, `cyc_valid`=0, `cyc_burst`=0 and `cyc_write`=0, and `word_addr` keeps its previous value.
- R2: The processor strobe `adsp_n`=0 is ignored while `en1_n`=1. If the controller strobe is high in that cycle, the block behaves as on a cycle with no strobe at all, and the enables are not examined.
- R3: A strobe cycle that selects the chip loads `addr_in` in full, so `word_addr` equals `addr_in` after that edge. `cyc_burst`=0 marks that first beat. `cyc_write` is 0 when the processor strobe started the cycle, whatever `wr_req` is. When the controller strobe started it, `cyc_write` equals `wr_req`.
- R4: With the chip selected and no strobe, `adv_n`=0 moves the low `CNT_W` address bits to the next beat and sets `cyc_burst`=1. `adv_n`=1 leaves `word_addr` unchanged, which suspends the burst.
- R5: When `lin_n`=0 at the load, beat k has low bits equal to (start + k) mod 4.
- R6: When `lin_n`=1 at the load, beat k has low bits equal to start XOR k. This interleaved order is the default.
- R7: After four advances the low bits return to their start value.
- R8: The upper bits `word_addr[15:2]` change only on a selecting strobe cycle.
- R9: A new address is accepted on every clock with no penalty. With the controller strobe held low, each edge loads a fresh `addr_in`.
- R10: A synchronous active-high `rst` gives `word_addr`=0, `cyc_valid`=0, `cyc_burst`=0, `cyc_write`=0 and `desel`=1.
- R11: The burst order is captured at the load. Changing `lin_n` during a burst does not change the sequence.
- R12: While deselected and with no strobe, `adv_n` has no effect. The block stays deselected and `word_addr` does not move.
- R13: On continue and suspend cycles of a selected burst, `cyc_write` follows `wr_req` of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| adsp_n | input | 1 | Processor address strobe, active low, masked by en1_n |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high suspends |
| en1_n | input | 1 | Chip enable, active low |
| en2 | input | 1 | Chip enable, active high |
| en3_n | input | 1 | Chip enable, active low |
| lin_n | input | 1 | Burst order select: 0 linear, 1 interleaved |
| wr_req | input | 1 | Write qualification of this cycle, 1 = write |
| addr_in | input | 16 | External word address |
| word_addr | output | 16 | Word address of the current beat |
| cyc_valid | output | 1 | The current cycle is a memory access |
| cyc_burst | output | 1 | The current access is a continuation beat |
| desel | output | 1 | The block is deselected |
| cyc_write | output | 1 | The current access is a write |

## Verification
The assertions take the strobe, enable and advance inputs as clean logic levels, sampled at the rising edge. They also take reset as synchronous and held for at least one edge. The bench changes every input only on the falling edge and leaves them steady through the following rising edge. It never drives an unknown value, so each property sees one well-defined command per cycle. Before each rising edge, a reference model of the requirements predicts the outcome of that cycle, and the result is compared just after the edge.

// File: rtl/bsram_seq_pkg.sv
package bsram_seq_pkg;

   typedef enum logic {
      ORD_INTERLEAVE = 1'b0,
      ORD_LINEAR     = 1'b1
   } burst_order_e;

   // build-time choice of the order logic that is instantiated
   localparam int ORDER_PIN   = 0;
   localparam int ORDER_LIN   = 1;
   localparam int ORDER_XOR   = 2;

   function automatic logic [7:0] beat_linear(input logic [7:0] start,
                                              input logic [7:0] offs);
      return start + offs;
   endfunction

   function automatic logic [7:0] beat_xor(input logic [7:0] start,
                                           input logic [7:0] offs);
      return start ^ offs;
   endfunction

endpackage

// File: rtl/bsram_strobe_decode.sv
module bsram_strobe_decode (
   input  logic adsp_n,
   input  logic adsc_n,
   input  logic en1_n,
   input  logic en2,
   input  logic en3_n,
   output logic cpu_go,
   output logic load,
   output logic enable
);

   // processor strobe only counts when the first enable is active
   always_comb begin
      cpu_go = ~adsp_n & ~en1_n;
      load   = cpu_go | ~adsc_n;
      enable = ~en1_n & en2 & ~en3_n;
   end

endmodule

// File: rtl/bsram_burst_ctr.sv
module bsram_burst_ctr
   import bsram_seq_pkg::*;
#(
   parameter int CNT_W      = 2,
   parameter int ORDER_MODE = ORDER_PIN
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] start_in,
   input  logic             lin_n,
   input  logic             step,
   output logic [CNT_W-1:0] beat
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("bsram_burst_ctr: CNT_W must be 1..8");
   end
   if (ORDER_MODE < ORDER_PIN || ORDER_MODE > ORDER_XOR) begin : g_bad_mode
      $error("bsram_burst_ctr: unknown ORDER_MODE");
   end

   logic [CNT_W-1:0] start_q;
   logic [CNT_W-1:0] off_q;
   burst_order_e     order_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         start_q <= '0;
         off_q   <= '0;
         order_q <= ORD_INTERLEAVE;
      end else if (load) begin
         start_q <= start_in;
         off_q   <= '0;
         order_q <= lin_n ? ORD_INTERLEAVE : ORD_LINEAR;
      end else if (step) begin
         off_q   <= off_q + ONE;
      end
   end

   logic [7:0] lin_val;
   logic [7:0] xor_val;
   always_comb begin
      lin_val = beat_linear(8'(start_q), 8'(off_q));
      xor_val = beat_xor(8'(start_q), 8'(off_q));
   end

   if (ORDER_MODE == ORDER_LIN) begin : g_lin
      assign beat = lin_val[CNT_W-1:0];
   end else if (ORDER_MODE == ORDER_XOR) begin : g_xor
      assign beat = xor_val[CNT_W-1:0];
   end else begin : g_pin
      assign beat = (order_q == ORD_LINEAR) ? lin_val[CNT_W-1:0]
                                            : xor_val[CNT_W-1:0];
   end

   // R4: an advance moves the offset by exactly one
   assert_step_one_R4: assert property (@(posedge clk) disable iff (rst)
      (step && !load) |=> (off_q == $past(off_q) + ONE));

   // R4: without load or step the beat address holds
   assert_hold_beat_R4: assert property (@(posedge clk) disable iff (rst)
      (!step && !load) |=> $stable(beat));

   // R11: the captured order is kept for the whole burst
   assert_order_kept_R11: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(order_q));

endmodule

// File: rtl/bsram_addr_seq.sv
module bsram_addr_seq
   import bsram_seq_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int CNT_W      = 2,
   parameter int ORDER_MODE = ORDER_PIN
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adsp_n,
   input  logic              adsc_n,
   input  logic              adv_n,
   input  logic              en1_n,
   input  logic              en2,
   input  logic              en3_n,
   input  logic              lin_n,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] word_addr,
   output logic              cyc_valid,
   output logic              cyc_burst,
   output logic              desel,
   output logic              cyc_write
);

   localparam int UP_W = ADDR_W - CNT_W;

   if (UP_W < 1) begin : g_bad_width
      $error("bsram_addr_seq: ADDR_W must exceed CNT_W");
   end

   logic cpu_go;
   logic load;
   logic enable;

   bsram_strobe_decode u_dec (
      .adsp_n (adsp_n),
      .adsc_n (adsc_n),
      .en1_n  (en1_n),
      .en2    (en2),
      .en3_n  (en3_n),
      .cpu_go (cpu_go),
      .load   (load),
      .enable (enable)
   );

   logic            sel_q;
   logic            first_q;
   logic            wr_q;
   logic [UP_W-1:0] upper_q;
   logic            take;
   logic            step;
   logic [CNT_W-1:0] beat;

   always_comb begin
      take = load & enable;
      step = ~load & sel_q & ~adv_n;
   end

   bsram_burst_ctr #(
      .CNT_W      (CNT_W),
      .ORDER_MODE (ORDER_MODE)
   ) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .load     (take),
      .start_in (addr_in[CNT_W-1:0]),
      .lin_n    (lin_n),
      .step     (step),
      .beat     (beat)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_q   <= 1'b0;
         first_q <= 1'b0;
         wr_q    <= 1'b0;
         upper_q <= '0;
      end else if (load) begin
         sel_q   <= enable;
         first_q <= enable;
         wr_q    <= enable & ~cpu_go & wr_req;
         if (enable) begin
            upper_q <= addr_in[ADDR_W-1:CNT_W];
         end
      end else begin
         first_q <= 1'b0;
         wr_q    <= sel_q & wr_req;
      end
   end

   always_comb begin
      word_addr = {upper_q, beat};
      cyc_valid = sel_q;
      cyc_burst = sel_q & ~first_q;
      desel     = ~sel_q;
      cyc_write = wr_q;
   end

   // R1: a strobe that finds the chip disabled deselects
   assert_desel_disabled_R1: assert property (@(posedge clk) disable iff (rst)
      (load && !enable) |=> (desel && !cyc_valid && !cyc_write));

   // R2: a masked processor strobe with no other strobe keeps the address
   assert_masked_cpu_R2: assert property (@(posedge clk) disable iff (rst)
      (!adsp_n && en1_n && adsc_n && adv_n) |=> $stable(word_addr));

   // R3: processor-started cycles read
   assert_cpu_read_R3: assert property (@(posedge clk) disable iff (rst)
      (cpu_go && enable) |=> (!cyc_write && cyc_valid && !cyc_burst));

   // R8: the upper bits move only on a selecting strobe
   assert_upper_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !take |=> $stable(word_addr[ADDR_W-1:CNT_W]));

   // R12: deselected with no strobe stays deselected
   assert_stay_desel_R12: assert property (@(posedge clk) disable iff (rst)
      (desel && !load) |=> (desel && $stable(word_addr)));

endmodule

// File: tb/bsram_addr_seq_test.sv
module bsram_addr_seq_test;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst;
   logic        adsp_n, adsc_n, adv_n, en1_n, en2, en3_n, lin_n, wr_req;
   logic [15:0] addr_in;
   logic [15:0] word_addr;
   logic        cyc_valid, cyc_burst, desel, cyc_write;

   bsram_addr_seq uut (
      .clk       (clk),
      .rst       (rst),
      .adsp_n    (adsp_n),
      .adsc_n    (adsc_n),
      .adv_n     (adv_n),
      .en1_n     (en1_n),
      .en2       (en2),
      .en3_n     (en3_n),
      .lin_n     (lin_n),
      .wr_req    (wr_req),
      .addr_in   (addr_in),
      .word_addr (word_addr),
      .cyc_valid (cyc_valid),
      .cyc_burst (cyc_burst),
      .desel     (desel),
      .cyc_write (cyc_write)
   );

   typedef struct {
      logic [15:0] addr;
      logic        v;
      logic        b;
      logic        d;
      logic        w;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done   = 0;

   // reference model state
   logic        m_sel   = 0;
   logic        m_first = 0;
   logic        m_wr    = 0;
   logic        m_lin   = 0;
   logic [13:0] m_up    = '0;
   logic [1:0]  m_start = '0;
   logic [1:0]  m_off   = '0;

   function automatic logic [15:0] m_addr();
      logic [1:0] lo;
      lo = m_lin ? 2'(m_start + m_off) : (m_start ^ m_off);
      return {m_up, lo};
   endfunction

   task automatic drive(input logic p_n, input logic c_n, input logic a_n,
                        input logic e1n, input logic e2v, input logic e3n,
                        input logic l_n, input logic wr, input logic [15:0] a,
                        input string tag);
      logic cpu, ld, en;
      exp_t e;
      @(negedge clk);
      adsp_n = p_n; adsc_n = c_n; adv_n = a_n;
      en1_n = e1n; en2 = e2v; en3_n = e3n;
      lin_n = l_n; wr_req = wr; addr_in = a;
      cpu = !p_n && !e1n;
      ld  = cpu || !c_n;
      en  = !e1n && e2v && !e3n;
      if (ld) begin
         if (en) begin
            m_sel = 1; m_first = 1; m_up = a[15:2]; m_start = a[1:0];
            m_off = 0; m_lin = !l_n; m_wr = cpu ? 1'b0 : wr;
         end else begin
            m_sel = 0; m_first = 0; m_wr = 0;
         end
      end else begin
         m_first = 0;
         if (m_sel && !a_n) m_off = m_off + 2'd1;
         m_wr = m_sel && wr;
      end
      e.addr = m_addr(); e.v = m_sel; e.b = m_sel && !m_first;
      e.d = !m_sel; e.w = m_wr; e.tag = tag;
      q.push_back(e);
   endtask

   // controller strobe, enabled
   task automatic ld_ctl(input logic [15:0] a, input logic l_n,
                         input logic wr, input string tag);
      drive(1, 0, 1, 0, 1, 0, l_n, wr, a, tag);
   endtask

   // no strobe
   task automatic nostb(input logic a_n, input logic l_n, input logic wr,
                        input string tag);
      drive(1, 1, a_n, 0, 1, 0, l_n, wr, 16'hFFFF, tag);
   endtask

   // monitor: compare just after each rising edge
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (word_addr !== e.addr || cyc_valid !== e.v || cyc_burst !== e.b ||
             desel !== e.d || cyc_write !== e.w) begin
            errors++;
            $display("FAIL %s: got addr=%h v=%b b=%b d=%b w=%b exp addr=%h v=%b b=%b d=%b w=%b",
                     e.tag, word_addr, cyc_valid, cyc_burst, desel, cyc_write,
                     e.addr, e.v, e.b, e.d, e.w);
         end
      end
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst = 1; adsp_n = 1; adsc_n = 1; adv_n = 1; en1_n = 0; en2 = 1;
      en3_n = 0; lin_n = 1; wr_req = 0; addr_in = 16'h0;
      repeat (3) @(negedge clk);
      // R10 reset state
      checks++;
      if (word_addr !== 16'h0 || cyc_valid !== 0 || cyc_burst !== 0 ||
          desel !== 1 || cyc_write !== 0) begin
         errors++;
         $display("FAIL R10: got addr=%h v=%b b=%b d=%b w=%b exp 0000 0 0 1 0",
                  word_addr, cyc_valid, cyc_burst, desel, cyc_write);
      end
      rst = 0;

      // R12 deselected, advance ignored
      nostb(0, 1, 0, "R12 idle advance");
      nostb(0, 1, 1, "R12 idle advance wr");

      // R6 R7 R8 interleaved burst from start 1, with suspend (R4)
      ld_ctl(16'h1235, 1, 0, "R3 R6 load");
      nostb(0, 1, 0, "R6 beat1");
      nostb(1, 1, 0, "R4 suspend");
      nostb(0, 1, 0, "R6 beat2");
      nostb(0, 1, 1, "R6 R13 beat3");
      nostb(0, 1, 0, "R7 wrap");
      nostb(0, 1, 0, "R8 R7 after wrap");

      // R5 linear from start 2, order change mid burst R11
      ld_ctl(16'hA5A6, 0, 1, "R3 R5 load write");
      nostb(0, 0, 1, "R5 R13 beat1");
      nostb(0, 1, 0, "R11 beat2 lin_n high");
      nostb(0, 1, 0, "R11 beat3");
      nostb(0, 0, 0, "R7 linear wrap");

      // R2 masked processor strobe during burst
      drive(0, 1, 1, 1, 1, 0, 1, 0, 16'h0F0F, "R2 masked hold");
      drive(0, 1, 0, 1, 0, 1, 1, 0, 16'h0F0F, "R2 masked advance");

      // R3 processor strobe forces read
      drive(0, 1, 1, 0, 1, 0, 1, 1, 16'h7773, "R3 cpu read");
      nostb(0, 1, 1, "R13 cpu burst write");
      nostb(1, 1, 0, "R13 suspend read");

      // R1 deselect via each enable
      drive(1, 0, 0, 0, 0, 0, 1, 1, 16'h1111, "R1 en2 low");
      nostb(0, 1, 0, "R12 stay desel");
      ld_ctl(16'h2222, 1, 0, "R1 reselect");
      drive(0, 1, 0, 0, 1, 1, 1, 0, 16'h3333, "R1 en3 high cpu");
      drive(1, 0, 0, 1, 1, 0, 1, 0, 16'h4444, "R1 en1 high ctl");

      // R9 back-to-back loads every cycle
      for (int i = 0; i < 6; i++) begin
         drive(1, 0, 0, 0, 1, 0, i[0], i[1], 16'(16'h0100 * i + i), "R9 new addr");
      end
      drive(0, 0, 0, 0, 1, 0, 1, 1, 16'hBEEF, "R3 R9 both strobes cpu read");

      repeat (3) @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule